// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer with Two-Bit Counters

This block predicts control transfers for an instruction fetch stage. A table of entries is indexed by the fetch address with its two low bits dropped, and wrapped to the table size. Each entry keeps a tag, a target address and a saturating two-bit confidence counter. In every cycle the fetch stage presents its current address. In the same cycle the block answers with a taken flag and with the target stored in the selected entry.

When a branch or jump retires, the pipeline reports the branch address and the address that actually followed it. The block works out for itself whether the transfer was taken: the following address differs from the branch address plus four. It then trains the counter of a matching entry. An entry held by a different branch is replaced instead. The target is captured only when the transfer was taken. A reported branch address of zero means that nothing retired in that cycle.

Top module: `btb_predictor`

## Requirements
- R1: After reset no fetch address hits, so `pred_taken` stays 0 until the first update, and `pred_target` reads 0.
- R2: The entry index is (address >> 2) modulo `ENTRIES`. The tag is the complete address, so two addresses that share an index but differ anywhere else never hit each other's entry.
- R3: `pred_taken` is 1 exactly when the selected entry is valid, its tag equals `fetch_pc`, and its counter is 2 or 3. `pred_target` always shows the stored target of the selected entry, whether the lookup hits or not.
- R4: A taken update on a matching entry raises its counter by one, and the counter stops at 3.
- R5: A not-taken update on a matching entry lowers its counter by one, and the counter stops at 0.
- R6: An update that misses writes the branch address into the tag and sets the counter to 2, with no training in that same update.
- R7: The target field takes `ret_next_pc` only on a taken update, whether that update hits or replaces the entry. On a not-taken update the old target stays.
- R8: An update counts as taken exactly when `ret_next_pc` is not equal to `ret_pc + 4`.
- R9: When `ret_pc` is 0 the table does not change, whatever `ret_next_pc` holds.
- R10: The lookup is combinational. A table write lands on the clock edge, so a lookup in the same cycle as an update still sees the old contents, and the new contents show from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_taken | output | 1 | Predicted taken for `fetch_pc` |
| pred_target | output | PC_W | Stored target of the selected entry |
| ret_pc | input | PC_W | Address of the retiring branch; 0 means no update |
| ret_next_pc | input | PC_W | Address that actually followed the retiring branch |

## Verification
The lookup and the training write can fall in the same cycle and touch the same entry. The bench provokes this by presenting one address both as the fetch address and as the retiring branch address in a single cycle. It also does so at random, because the addresses are drawn from a small pool that includes aliasing pairs. In that cycle the outputs are judged against the model's state before the update, and in the next cycle against its state after the update. Replacement and training on aliasing pairs in back-to-back cycles are judged the same way.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ENTRIES = 512,
  parameter int PC_W    = 32,
  parameter int CTR_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] pred_target,
  input  logic [PC_W-1:0] ret_pc,
  input  logic [PC_W-1:0] ret_next_pc
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1) << (CTR_W - 1);
  localparam logic [PC_W-1:0]  STEP     = PC_W'(4);

  logic [PC_W-1:0]  tag_q [ENTRIES];
  logic [PC_W-1:0]  tgt_q [ENTRIES];
  logic [CTR_W-1:0] ctr_q [ENTRIES];
  logic             val_q [ENTRIES];

  function automatic logic [IDX_W-1:0] slot(input logic [PC_W-1:0] a);
    logic [PC_W-1:0] w;
    w = (a >> 2) % PC_W'(ENTRIES);
    return w[IDX_W-1:0];
  endfunction

  logic [IDX_W-1:0] f_idx, u_idx;
  logic             f_hit, u_hit, u_en, u_taken;
  logic [CTR_W-1:0] u_ctr;

  assign f_idx       = slot(fetch_pc);
  assign f_hit       = val_q[f_idx] && (tag_q[f_idx] == fetch_pc);
  assign pred_taken  = f_hit && ctr_q[f_idx][CTR_W-1];
  assign pred_target = tgt_q[f_idx];

  assign u_en    = (ret_pc != '0);
  assign u_taken = (ret_next_pc != ret_pc + STEP);
  assign u_idx   = slot(ret_pc);
  assign u_hit   = val_q[u_idx] && (tag_q[u_idx] == ret_pc);
  assign u_ctr   = ctr_q[u_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        val_q[i] <= 1'b0;
        tag_q[i] <= '0;
        tgt_q[i] <= '0;
        ctr_q[i] <= CTR_INIT;
      end
    end else if (u_en) begin
      if (u_hit) begin
        if (u_taken && u_ctr != CTR_MAX)
          ctr_q[u_idx] <= u_ctr + 1'b1;
        else if (!u_taken && u_ctr != '0)
          ctr_q[u_idx] <= u_ctr - 1'b1;
      end else begin
        val_q[u_idx] <= 1'b1;
        tag_q[u_idx] <= ret_pc;
        ctr_q[u_idx] <= CTR_INIT;
      end
      if (u_taken)
        tgt_q[u_idx] <= ret_next_pc;
    end
  end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W  = 32,
  parameter int CTR_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_taken,
  input logic [PC_W-1:0] pred_target,
  input logic [PC_W-1:0] ret_pc,
  input logic [PC_W-1:0] ret_next_pc,
  input logic            u_hit,
  input logic [CTR_W-1:0] u_ctr
);
  logic seen_q;
  logic tkn;
  assign tkn = (ret_next_pc != ret_pc + PC_W'(4));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_q <= 1'b0;
    else if (ret_pc != '0) seen_q <= 1'b1;

  assert_reset_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !pred_taken);

  assert_target_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_pc != '0 && tkn) && fetch_pc == $past(ret_pc))
      |-> pred_target == $past(ret_next_pc));

  assert_new_entry_weak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_pc != '0 && !u_hit) && fetch_pc == $past(ret_pc)) |-> pred_taken);

  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_pc != '0 && u_hit && !tkn && u_ctr == '0) && fetch_pc == $past(ret_pc))
      |-> !pred_taken);

  assert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_pc != '0 && u_hit && tkn && u_ctr == {CTR_W{1'b1}}) && fetch_pc == $past(ret_pc))
      |-> pred_taken);

  assert_idle_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_pc == '0) && fetch_pc == $past(fetch_pc))
      |-> (pred_taken == $past(pred_taken) && pred_target == $past(pred_target)));
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W), .CTR_W(CTR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
  .pred_target(pred_target), .ret_pc(ret_pc), .ret_next_pc(ret_next_pc),
  .u_hit(u_hit), .u_ctr(u_ctr));

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;
  localparam int ENT = 512;
  localparam int W   = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] fetch_pc = '0, ret_pc = '0, ret_next_pc = '0;
  logic         pred_taken;
  logic [W-1:0] pred_target;

  btb_predictor #(.ENTRIES(ENT), .PC_W(W), .CTR_W(2)) i_btb_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .pred_target(pred_target), .ret_pc(ret_pc), .ret_next_pc(ret_next_pc));

  always #2.5 clk = ~clk;

  bit           m_val [ENT];
  logic [W-1:0] m_tag [ENT];
  logic [W-1:0] m_tgt [ENT];
  int           m_ctr [ENT];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int mi(input logic [W-1:0] a);
    return int'((a >> 2) % W'(ENT));
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update(input logic [W-1:0] rp, input logic [W-1:0] rn);
    int i;
    bit tk;
    if (rp == '0) return;
    i  = mi(rp);
    tk = (rn != rp + 32'd4);
    if (m_val[i] && m_tag[i] == rp) begin
      if (tk && m_ctr[i] < 3) m_ctr[i]++;
      else if (!tk && m_ctr[i] > 0) m_ctr[i]--;
    end else begin
      m_val[i] = 1; m_tag[i] = rp; m_ctr[i] = 2;
    end
    if (tk) m_tgt[i] = rn;
  endtask

  task automatic cyc(input logic [W-1:0] fp, input logic [W-1:0] rp,
                     input logic [W-1:0] rn, input string req);
    int i;
    bit hit;
    @(negedge clk);
    fetch_pc = fp; ret_pc = rp; ret_next_pc = rn;
    #1;
    i   = mi(fp);
    hit = m_val[i] && m_tag[i] == fp;
    chk(req, W'(pred_taken), W'(hit && m_ctr[i] >= 2));
    chk(req, pred_target, m_tgt[i]);
    @(posedge clk);
    model_update(rp, rn);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] A, B, C;
    logic [W-1:0] pool [16];
    for (int i = 0; i < ENT; i++) begin
      m_val[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    A = 32'h0000_1000; B = 32'h0000_1204; C = A + ENT * 4;
    // R1: nothing hits after reset
    cyc(A, '0, '0, "R1");
    cyc(32'h0000_0000, '0, '0, "R1");
    cyc(32'hFFFF_FFFC, '0, '0, "R1");
    // R8 taken because next != pc+4; R6 new entry weakly taken; R7 target
    cyc(B, A, 32'h0000_2000, "R8");
    cyc(A, '0, '0, "R6");
    // R10 same-cycle update not visible, then visible
    cyc(B, B, 32'h0000_3000, "R10");
    cyc(B, '0, '0, "R10");
    // R5 decrement with floor, target kept (R7)
    cyc(A, A, A + 32'd4, "R5");
    cyc(A, A, A + 32'd4, "R5");
    cyc(A, A, A + 32'd4, "R5");
    cyc(A, '0, '0, "R7");
    // R4 increment with ceiling
    cyc(A, A, 32'h0000_2400, "R4");
    cyc(A, A, 32'h0000_2400, "R4");
    cyc(A, A, 32'h0000_2400, "R4");
    cyc(A, A, 32'h0000_2400, "R4");
    cyc(A, A, A + 32'd4, "R4");
    cyc(A, '0, '0, "R4");
    // R2 alias shares slot but not tag; R3 target shown anyway
    cyc(C, '0, '0, "R2");
    cyc(C, C, C + 32'd4, "R3");
    cyc(C, '0, '0, "R6");
    cyc(A, '0, '0, "R2");
    // R9 zero branch address changes nothing
    cyc(C, '0, 32'h5555_5554, "R9");
    cyc(C, '0, '0, "R9");

    void'($urandom(32'd20240611));
    for (int k = 0; k < 16; k++)
      pool[k] = 32'h0000_0100 + (k % 8) * 4 + (k / 8) * ENT * 4;
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] fp, rp, rn;
      fp = pool[$urandom_range(15)];
      rp = ($urandom_range(9) < 2) ? '0 : pool[$urandom_range(15)];
      rn = ($urandom_range(1) == 1) ? rp + 32'd4 : {$urandom} & 32'hFFFF_FFFC;
      cyc(fp, rp, rn, "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule